// File: doc/BRIEF.md
# Register stack frame rename unit

This block keeps the current register window of a processor whose stacked registers are allocated per call. It holds a frame marker (frame size, locals size, rotating size), a physical base pointer into a circular stacked register file, a saved-frame word and a return-link register. Logical stacked registers start at 32. Logical 32 is always the first register of the current frame and maps to physical `(base + idx - 32) mod 96`.

Commands arrive on `cmd`, one per cycle, and take effect at the clock edge. A call (`cmd`=1) saves the frame state and slides the window so that the caller's outputs become the callee's inputs. The new frame has no locals, no outputs and no rotating part. An alloc (`cmd`=2) resizes the window in place, and may be issued again in the same frame. It writes the saved-frame word into a chosen register of the resized frame. A return (`cmd`=3) brings back the caller's frame from the saved-frame word. A load (`cmd`=4) sets the saved-frame word from `wr_data`. All other codes are no-ops. A combinational read port and a clocked write port reach the stacked registers through the current frame. An alloc that would push the live frames past the physical file is refused and reported on `ovf_flag`.

A two-state machine records the kind of frame in force. FR_DEFAULT is the frame made by a call and not resized since. FR_SIZED is a frame set up by an accepted alloc. The transitions are:
- reset → FR_DEFAULT
- call → FR_DEFAULT
- accepted alloc → FR_SIZED
- refused alloc → state held
- return → the state saved in bit 25 of the saved-frame word
- load and no-op → state held

Top module: `regstk_frame_unit`

## Requirements
- R1: After reset, `cur_sof`, `cur_sol`, `cur_sor`, `cur_base`, `pfs_value` and `ret_link` are 0, `ovf_flag` is 0 and `frame_is_default` is 1.
- R2: A legal logical index `idx` reaches physical register `(cur_base + idx - 32) mod 96`. `rd_data` is combinational from the current frame. A write with `wr_en` lands at the clock edge, and the index wraps past physical 95.
- R3: An index below 32, or with `idx - 32 >= cur_sof`, raises `rd_illegal` for reads and `wr_illegal` for writes (with `wr_en`). Such a write changes no register, and such a read returns 0.
- R4: A call loads `pfs_value` with the pre-call state before renaming. The layout is bits [6:0] frame size, [13:7] locals size, [17:14] rotating size, [24:18] base, and [25] equal to 1 if the pre-call state was FR_DEFAULT.
- R5: A call sets the base to `(base + locals) mod 96`, the frame size to frame size minus locals, and locals and rotating size to 0. It also enters FR_DEFAULT, so the caller's first output becomes logical 32.
- R6: A call stores `call_ret_addr` into `ret_link`.
- R7: An accepted alloc sets the frame size to `alc_in+alc_loc+alc_out`, the locals size to `alc_in+alc_loc` and the rotating size to `alc_rot`. It leaves the base unchanged and enters FR_SIZED.
- R8: An accepted alloc writes `pfs_value` (zero-extended) into logical `alc_dst`, mapped through the resized frame, unless `alc_dst` is illegal in that frame. The write port is ignored in an alloc cycle.
- R9: Alloc may be repeated within one frame, and each accepted alloc replaces the sizes again without moving the base or touching register contents.
- R10: An alloc is refused when the locals of all frames below plus the new frame size exceed 96. A refused alloc leaves frame, base and registers unchanged, and `ovf_flag` is 1 only in the cycle after it.
- R11: A return restores frame size, locals, rotating size, base and machine state from `pfs_value`. Register contents are unchanged.
- R12: A load (`cmd`=4) sets `pfs_value` to `wr_data[25:0]`, leaves the frame unchanged and ignores the write port in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | 0 none, 1 call, 2 alloc, 3 return, 4 load saved-frame word |
| alc_in | input | 7 | Alloc input count |
| alc_loc | input | 7 | Alloc local count |
| alc_out | input | 7 | Alloc output count |
| alc_rot | input | 4 | Alloc rotating size, units of 8 |
| alc_dst | input | 7 | Logical register receiving the saved-frame word on alloc |
| call_ret_addr | input | 32 | Return address captured by a call |
| rd_idx | input | 7 | Logical read index |
| rd_data | output | 32 | Read data |
| rd_illegal | output | 1 | Read index outside the frame |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 7 | Logical write index |
| wr_data | input | 32 | Write data; low 26 bits also feed the load command |
| wr_illegal | output | 1 | Enabled write outside the frame |
| cur_sof | output | 7 | Current frame size |
| cur_sol | output | 7 | Current locals size |
| cur_sor | output | 4 | Current rotating size |
| cur_base | output | 7 | Physical base of logical 32 |
| pfs_value | output | 26 | Saved-frame word |
| ret_link | output | 32 | Return-link register |
| ovf_flag | output | 1 | Pulse after a refused alloc |
| frame_is_default | output | 1 | State is FR_DEFAULT |

## Verification
An alloc and a register write can meet in one cycle, and so can the command edge and the read of a register written by the alloc. The bench drives an alloc together with an enabled write to a different register of the callee. It then reads back both registers. The alloc target must hold the saved-frame word, and the other register must keep the value it had before. A second case aims the alloc target outside the shrunken frame, then re-grows the frame to show that the old contents survived.

// File: rtl/regstk_pkg.sv
package regstk_pkg;

    localparam int SZ_W     = 7;
    localparam int ROT_W    = 4;
    localparam int LOG_BASE = 32;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_CALL  = 3'd1,
        CMD_ALLOC = 3'd2,
        CMD_RET   = 3'd3,
        CMD_LDPFS = 3'd4
    } cmd_e;

    typedef enum logic {
        FR_DEFAULT = 1'b0,
        FR_SIZED   = 1'b1
    } frame_e;

    // saved-frame word: dflt[25] base[24:18] sor[17:14] sol[13:7] sof[6:0]
    typedef struct packed {
        logic             dflt;
        logic [SZ_W-1:0]  base;
        logic [ROT_W-1:0] sor;
        logic [SZ_W-1:0]  sol;
        logic [SZ_W-1:0]  sof;
    } pfs_t;

    localparam int PFS_W = $bits(pfs_t);

endpackage

// File: rtl/regstk_map.sv
module regstk_map
    import regstk_pkg::*;
#(
    parameter int PHYS_REGS = 96
) (
    input  logic [SZ_W-1:0] base,
    input  logic [SZ_W-1:0] sof,
    input  logic [SZ_W-1:0] idx,
    output logic [SZ_W-1:0] phys,
    output logic            illegal
);

    localparam logic [SZ_W-1:0] FIRST = SZ_W'(LOG_BASE);
    localparam logic [SZ_W:0]   WRAP  = (SZ_W+1)'(PHYS_REGS);

    logic [SZ_W-1:0] offset;
    logic [SZ_W:0]   sum;

    always_comb begin
        offset  = idx - FIRST;
        sum     = (SZ_W+1)'(base) + (SZ_W+1)'(offset);
        phys    = SZ_W'((sum >= WRAP) ? sum - WRAP : sum);
        illegal = (idx < FIRST) || (offset >= sof);
    end

endmodule

// File: rtl/regstk_file.sv
module regstk_file
    import regstk_pkg::*;
#(
    parameter int PHYS_REGS = 96,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SZ_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SZ_W-1:0]   raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [PHYS_REGS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = mem[raddr];
    end

endmodule

// File: rtl/regstk_frame_ctl.sv
module regstk_frame_ctl
    import regstk_pkg::*;
#(
    parameter int PHYS_REGS = 96,
    parameter int LINK_W    = 32,
    parameter int DEPTH_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [SZ_W-1:0]   alc_in,
    input  logic [SZ_W-1:0]   alc_loc,
    input  logic [SZ_W-1:0]   alc_out,
    input  logic [ROT_W-1:0]  alc_rot,
    input  logic [LINK_W-1:0] call_link,
    input  logic [PFS_W-1:0]  pfs_load,
    output logic [SZ_W-1:0]   sof,
    output logic [SZ_W-1:0]   sol,
    output logic [ROT_W-1:0]  sor,
    output logic [SZ_W-1:0]   base,
    output pfs_t              pfs,
    output logic [LINK_W-1:0] link,
    output logic              ovf,
    output logic              is_default,
    output logic              alloc_ok,
    output logic [SZ_W-1:0]   alloc_sof
);

    localparam int              SUM_W = SZ_W + 2;
    localparam logic [DEPTH_W:0] LIMIT = (DEPTH_W+1)'(PHYS_REGS);
    localparam logic [SZ_W:0]    WRAP  = (SZ_W+1)'(PHYS_REGS);

    frame_e            state_q, state_d;
    logic [SZ_W-1:0]   sof_q, sol_q, base_q;
    logic [ROT_W-1:0]  sor_q;
    logic [DEPTH_W-1:0] depth_q;   // locals held by all frames below this one
    pfs_t              pfs_q;
    logic [LINK_W-1:0] link_q;
    logic              ovf_q;

    logic [SUM_W-1:0]  want_sof;
    logic [DEPTH_W:0]  need;
    logic [SZ_W:0]     bsum;
    logic [SZ_W-1:0]   base_adv;
    pfs_t              pfs_snap;

    always_comb begin
        want_sof  = SUM_W'(alc_in) + SUM_W'(alc_loc) + SUM_W'(alc_out);
        need      = (DEPTH_W+1)'(depth_q) + (DEPTH_W+1)'(want_sof);
        alloc_ok  = (cmd == CMD_ALLOC) && (need <= LIMIT);
        alloc_sof = SZ_W'(want_sof);
        bsum      = (SZ_W+1)'(base_q) + (SZ_W+1)'(sol_q);
        base_adv  = SZ_W'((bsum >= WRAP) ? bsum - WRAP : bsum);
        pfs_snap  = '{dflt: (state_q == FR_DEFAULT), base: base_q,
                      sor: sor_q, sol: sol_q, sof: sof_q};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_DEFAULT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (cmd)
            CMD_CALL:  state_d = FR_DEFAULT;
            CMD_ALLOC: if (alloc_ok) state_d = FR_SIZED;
            CMD_RET:   state_d = pfs_q.dflt ? FR_DEFAULT : FR_SIZED;
            default:   state_d = state_q;
        endcase
    end

    // outputs
    always_comb begin
        is_default = (state_q == FR_DEFAULT);
        sof        = sof_q;
        sol        = sol_q;
        sor        = sor_q;
        base       = base_q;
        pfs        = pfs_q;
        link       = link_q;
        ovf        = ovf_q;
    end

    // frame marker, base, depth, saved word, link
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sof_q   <= '0;
            sol_q   <= '0;
            sor_q   <= '0;
            base_q  <= '0;
            depth_q <= '0;
            pfs_q   <= '0;
            link_q  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            ovf_q <= (cmd == CMD_ALLOC) && !alloc_ok;
            unique case (cmd)
                CMD_CALL: begin
                    pfs_q   <= pfs_snap;
                    base_q  <= base_adv;
                    sof_q   <= sof_q - sol_q;
                    sol_q   <= '0;
                    sor_q   <= '0;
                    depth_q <= depth_q + DEPTH_W'(sol_q);
                    link_q  <= call_link;
                end
                CMD_ALLOC: begin
                    if (alloc_ok) begin
                        sof_q <= alloc_sof;
                        sol_q <= alc_in + alc_loc;
                        sor_q <= alc_rot;
                    end
                end
                CMD_RET: begin
                    sof_q   <= pfs_q.sof;
                    sol_q   <= pfs_q.sol;
                    sor_q   <= pfs_q.sor;
                    base_q  <= pfs_q.base;
                    depth_q <= depth_q - DEPTH_W'(pfs_q.sol);
                end
                CMD_LDPFS: pfs_q <= pfs_t'(pfs_load);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/regstk_frame_unit.sv
module regstk_frame_unit
    import regstk_pkg::*;
#(
    parameter int PHYS_REGS = 96,
    parameter int DATA_W    = 32,
    parameter int LINK_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [SZ_W-1:0]   alc_in,
    input  logic [SZ_W-1:0]   alc_loc,
    input  logic [SZ_W-1:0]   alc_out,
    input  logic [ROT_W-1:0]  alc_rot,
    input  logic [SZ_W-1:0]   alc_dst,
    input  logic [LINK_W-1:0] call_ret_addr,
    input  logic [SZ_W-1:0]   rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_illegal,
    input  logic              wr_en,
    input  logic [SZ_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_illegal,
    output logic [SZ_W-1:0]   cur_sof,
    output logic [SZ_W-1:0]   cur_sol,
    output logic [ROT_W-1:0]  cur_sor,
    output logic [SZ_W-1:0]   cur_base,
    output logic [PFS_W-1:0]  pfs_value,
    output logic [LINK_W-1:0] ret_link,
    output logic              ovf_flag,
    output logic              frame_is_default
);

    localparam int NMAP = 3;   // 0 read, 1 port write, 2 alloc target

    cmd_e            cmd_c;
    pfs_t            pfs_q;
    logic            alloc_ok;
    logic [SZ_W-1:0] alloc_sof;

    logic [SZ_W-1:0] m_idx  [NMAP];
    logic [SZ_W-1:0] m_sof  [NMAP];
    logic [SZ_W-1:0] m_phys [NMAP];
    logic            m_ill  [NMAP];

    logic              port_wr, alloc_wr, f_we;
    logic [SZ_W-1:0]   f_waddr;
    logic [DATA_W-1:0] f_wdata, f_rdata;

    assign cmd_c = cmd_e'(cmd);

    regstk_frame_ctl #(
        .PHYS_REGS (PHYS_REGS),
        .LINK_W    (LINK_W)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd_c),
        .alc_in     (alc_in),
        .alc_loc    (alc_loc),
        .alc_out    (alc_out),
        .alc_rot    (alc_rot),
        .call_link  (call_ret_addr),
        .pfs_load   (wr_data[PFS_W-1:0]),
        .sof        (cur_sof),
        .sol        (cur_sol),
        .sor        (cur_sor),
        .base       (cur_base),
        .pfs        (pfs_q),
        .link       (ret_link),
        .ovf        (ovf_flag),
        .is_default (frame_is_default),
        .alloc_ok   (alloc_ok),
        .alloc_sof  (alloc_sof)
    );

    always_comb begin
        m_idx[0] = rd_idx;   m_sof[0] = cur_sof;
        m_idx[1] = wr_idx;   m_sof[1] = cur_sof;
        m_idx[2] = alc_dst;  m_sof[2] = alloc_sof;
    end

    for (genvar g = 0; g < NMAP; g++) begin : g_map
        regstk_map #(
            .PHYS_REGS (PHYS_REGS)
        ) u_map (
            .base    (cur_base),
            .sof     (m_sof[g]),
            .idx     (m_idx[g]),
            .phys    (m_phys[g]),
            .illegal (m_ill[g])
        );
    end

    always_comb begin
        port_wr    = wr_en && !m_ill[1] &&
                     (cmd_c != CMD_ALLOC) && (cmd_c != CMD_LDPFS);
        alloc_wr   = alloc_ok && !m_ill[2];
        f_we       = port_wr || alloc_wr;
        f_waddr    = alloc_wr ? m_phys[2] : m_phys[1];
        f_wdata    = alloc_wr ? DATA_W'(pfs_q) : wr_data;
        rd_illegal = m_ill[0];
        wr_illegal = wr_en && m_ill[1];
        rd_data    = m_ill[0] ? '0 : f_rdata;
        pfs_value  = pfs_q;
    end

    regstk_file #(
        .PHYS_REGS (PHYS_REGS),
        .DATA_W    (DATA_W)
    ) u_file (
        .clk   (clk),
        .we    (f_we),
        .waddr (f_waddr),
        .wdata (f_wdata),
        .raddr (m_phys[0]),
        .rdata (f_rdata)
    );

endmodule

// File: rtl/regstk_chk.sv
module regstk_chk
    import regstk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LINK_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd,
    input logic [LINK_W-1:0] call_ret_addr,
    input logic [SZ_W-1:0]   rd_idx,
    input logic              rd_illegal,
    input logic              wr_en,
    input logic [SZ_W-1:0]   wr_idx,
    input logic              wr_illegal,
    input logic [SZ_W-1:0]   cur_sof,
    input logic [SZ_W-1:0]   cur_sol,
    input logic [ROT_W-1:0]  cur_sor,
    input logic [SZ_W-1:0]   cur_base,
    input logic [PFS_W-1:0]  pfs_value,
    input logic [LINK_W-1:0] ret_link,
    input logic              ovf_flag,
    input logic              frame_is_default
);

    localparam int BASE_LSB = 2*SZ_W + ROT_W;

    AST_CALL_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd1) |=> (pfs_value == {$past(frame_is_default), $past(cur_base),
                                         $past(cur_sor), $past(cur_sol), $past(cur_sof)})); // R4

    AST_CALL_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd1) |=> (cur_sol == '0 && cur_sor == '0 && frame_is_default)); // R5

    AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd1) |=> (ret_link == $past(call_ret_addr))); // R6

    AST_ALLOC_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd2) |=> $stable(cur_base)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> ($stable(cur_sof) && $stable(cur_sol) && $stable(cur_base))); // R10

    AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd3) |=> (cur_sof == $past(pfs_value[SZ_W-1:0]) &&
                           cur_base == $past(pfs_value[BASE_LSB +: SZ_W]))); // R11

    AST_RD_LOW_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx < SZ_W'(LOG_BASE)) |-> rd_illegal); // R3

    AST_WR_LOW_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx < SZ_W'(LOG_BASE)) |-> wr_illegal); // R3

endmodule

bind regstk_frame_unit regstk_chk u_chk (.*);

// File: tb/sim_regstk_frame_unit.sv
`timescale 1ns/100ps
module sim_regstk_frame_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = '0;
    logic [6:0]  alc_in = '0, alc_loc = '0, alc_out = '0, alc_dst = '0;
    logic [3:0]  alc_rot = '0;
    logic [31:0] call_ret_addr = '0;
    logic [6:0]  rd_idx = 7'd32, wr_idx = 7'd32;
    logic [31:0] rd_data, wr_data = '0;
    logic        rd_illegal, wr_en = 1'b0, wr_illegal;
    logic [6:0]  cur_sof, cur_sol, cur_base;
    logic [3:0]  cur_sor;
    logic [25:0] pfs_value;
    logic [31:0] ret_link;
    logic        ovf_flag, frame_is_default;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    regstk_frame_unit u0 (.*);

    typedef struct packed {
        logic [2:0]  c;
        logic [6:0]  i, l, o;
        logic [3:0]  r;
        logic [6:0]  d;
        logic [31:0] a;
        logic [6:0]  e_sof, e_sol;
        logic [3:0]  e_sor;
        logic [6:0]  e_base;
        logic        e_ovf, e_def;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TBL [NV] = '{
        '{3'd2, 7'd0, 7'd4,  7'd3, 4'd0, 7'd32, 32'h0,    7'd7,  7'd4,  4'd0, 7'd0, 1'b0, 1'b0, 4'd7},  // R7 first alloc
        '{3'd2, 7'd0, 7'd5,  7'd6, 4'd1, 7'd33, 32'h0,    7'd11, 7'd5,  4'd1, 7'd0, 1'b0, 1'b0, 4'd9},  // R9 re-alloc
        '{3'd1, 7'd0, 7'd0,  7'd0, 4'd0, 7'd32, 32'h1000, 7'd6,  7'd0,  4'd0, 7'd5, 1'b0, 1'b1, 4'd5},  // R5 call
        '{3'd2, 7'd6, 7'd80, 7'd6, 4'd0, 7'd38, 32'h0,    7'd6,  7'd0,  4'd0, 7'd5, 1'b1, 1'b1, 4'd10}, // R10 refused
        '{3'd2, 7'd6, 7'd79, 7'd6, 4'd0, 7'd38, 32'h0,    7'd91, 7'd85, 4'd0, 7'd5, 1'b0, 1'b0, 4'd7},  // R7 exact fit
        '{3'd2, 7'd6, 7'd2,  7'd2, 4'd0, 7'd40, 32'h0,    7'd10, 7'd8,  4'd0, 7'd5, 1'b0, 1'b0, 4'd9},  // R9 shrink
        '{3'd3, 7'd0, 7'd0,  7'd0, 4'd0, 7'd32, 32'h0,    7'd11, 7'd5,  4'd1, 7'd0, 1'b0, 1'b0, 4'd11}  // R11 return
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] c, input logic [6:0] i, input logic [6:0] l,
                        input logic [6:0] o, input logic [3:0] r, input logic [6:0] d,
                        input logic [31:0] a, input logic we, input logic [6:0] wi,
                        input logic [31:0] wd);
        @(negedge clk);
        cmd = c; alc_in = i; alc_loc = l; alc_out = o; alc_rot = r; alc_dst = d;
        call_ret_addr = a; wr_en = we; wr_idx = wi; wr_data = wd;
        @(posedge clk);
        #1;
        cmd = 3'd0; wr_en = 1'b0;
    endtask

    task automatic wr(input logic [6:0] idx, input logic [31:0] v);
        step(3'd0, 7'd0, 7'd0, 7'd0, 4'd0, 7'd32, 32'h0, 1'b1, idx, v);
    endtask

    task automatic rd(input logic [6:0] idx);
        rd_idx = idx;
        #1;
    endtask

    task automatic reset_check();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 sof", 32'(cur_sof), 0);
        check("R1 sol", 32'(cur_sol), 0);
        check("R1 sor", 32'(cur_sor), 0);
        check("R1 base", 32'(cur_base), 0);
        check("R1 pfs", 32'(pfs_value), 0);
        check("R1 link", ret_link, 0);
        check("R1 ovf", 32'(ovf_flag), 0);
        check("R1 default", 32'(frame_is_default), 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_pfs;
        exp_pfs = 32'd0;
        reset_check();

        for (int k = 0; k < NV; k++) begin
            step(TBL[k].c, TBL[k].i, TBL[k].l, TBL[k].o, TBL[k].r, TBL[k].d,
                 TBL[k].a, 1'b0, 7'd32, 32'h0);
            check($sformatf("R%0d vec%0d sof", TBL[k].req, k), 32'(cur_sof), 32'(TBL[k].e_sof));
            check($sformatf("R%0d vec%0d sol", TBL[k].req, k), 32'(cur_sol), 32'(TBL[k].e_sol));
            check($sformatf("R%0d vec%0d sor", TBL[k].req, k), 32'(cur_sor), 32'(TBL[k].e_sor));
            check($sformatf("R%0d vec%0d base", TBL[k].req, k), 32'(cur_base), 32'(TBL[k].e_base));
            check($sformatf("R%0d vec%0d ovf", TBL[k].req, k), 32'(ovf_flag), 32'(TBL[k].e_ovf));
            check($sformatf("R%0d vec%0d default", TBL[k].req, k), 32'(frame_is_default), 32'(TBL[k].e_def));
            if (TBL[k].c == 3'd1) begin
                exp_pfs = 32'd17035;   // R4: sof 11, sol 5, sor 1, base 0, sized
                check("R4 saved word", 32'(pfs_value), exp_pfs);
                check("R6 link", ret_link, TBL[k].a);
            end
            if (TBL[k].c == 3'd2 && !TBL[k].e_ovf && (TBL[k].d - 7'd32) < TBL[k].e_sof) begin
                rd(TBL[k].d);
                check("R8 alloc target", rd_data, exp_pfs);
            end
        end

        // R3 illegal indices in frame of size 11
        rd(7'd43); check("R3 read above frame", 32'(rd_illegal), 1);
        rd(7'd42); check("R3 read top legal", 32'(rd_illegal), 0);
        rd(7'd20); check("R3 read below 32", 32'(rd_illegal), 1);
        wr_en = 1'b1; wr_idx = 7'd45; #1;
        check("R3 write flag", 32'(wr_illegal), 1);
        wr_en = 1'b0;

        // R2 write and read through the frame
        wr(7'd42, 32'hA0A0_0001);
        wr(7'd36, 32'hB0B0_0002);
        rd(7'd42); check("R2 read 42", rd_data, 32'hA0A0_0001);
        rd(7'd36); check("R2 read 36", rd_data, 32'hB0B0_0002);

        // R5 call: caller output 42 is callee 37
        step(3'd1, 7'd0, 7'd0, 7'd0, 4'd0, 7'd32, 32'h2468, 1'b0, 7'd32, 32'h0);
        check("R5 base", 32'(cur_base), 5);
        check("R5 sof", 32'(cur_sof), 6);
        check("R6 link", ret_link, 32'h2468);
        rd(7'd37); check("R5 input is caller output", rd_data, 32'hA0A0_0001);
        rd(7'd38); check("R3 beyond default frame", 32'(rd_illegal), 1);

        // R8 alloc and port write in the same cycle
        wr(7'd33, 32'h0000_D00D);
        step(3'd2, 7'd6, 7'd2, 7'd0, 4'd0, 7'd38, 32'h0, 1'b1, 7'd33, 32'hCCCC_CCCC);
        check("R7 sof", 32'(cur_sof), 8);
        rd(7'd38); check("R8 target gets saved word", rd_data, 32'd17035);
        rd(7'd33); check("R8 port write ignored", rd_data, 32'h0000_D00D);

        // R11 return leaves contents
        step(3'd3, 7'd0, 7'd0, 7'd0, 4'd0, 7'd32, 32'h0, 1'b0, 7'd32, 32'h0);
        check("R11 base", 32'(cur_base), 0);
        check("R11 sof", 32'(cur_sof), 11);
        check("R11 default", 32'(frame_is_default), 0);
        rd(7'd36); check("R11 local kept", rd_data, 32'hB0B0_0002);

        // R12 load saved word, write port ignored
        wr(7'd34, 32'hF0F0_0003);
        step(3'd4, 7'd0, 7'd0, 7'd0, 4'd0, 7'd32, 32'h0, 1'b1, 7'd34, 32'd57147412);
        check("R12 saved word", 32'(pfs_value), 32'd57147412);
        check("R12 frame kept", 32'(cur_sof), 11);
        rd(7'd34); check("R12 no write", rd_data, 32'hF0F0_0003);

        // R11 return into base 90, default state; R2 wrap
        step(3'd3, 7'd0, 7'd0, 7'd0, 4'd0, 7'd32, 32'h0, 1'b0, 7'd32, 32'h0);
        check("R11 base 90", 32'(cur_base), 90);
        check("R11 default restored", 32'(frame_is_default), 1);
        wr(7'd40, 32'hE0E0_0004);
        rd(7'd40); check("R2 wrapped read", rd_data, 32'hE0E0_0004);
        step(3'd4, 7'd0, 7'd0, 7'd0, 4'd0, 7'd32, 32'h0, 1'b0, 7'd32, 32'd11);
        step(3'd3, 7'd0, 7'd0, 7'd0, 4'd0, 7'd32, 32'h0, 1'b0, 7'd32, 32'h0);
        rd(7'd34); check("R2 wrap lands on physical 2", rd_data, 32'hE0E0_0004);

        // R8 target outside resized frame is not written
        wr(7'd40, 32'h6060_0005);
        step(3'd2, 7'd0, 7'd2, 7'd0, 4'd0, 7'd40, 32'h0, 1'b0, 7'd32, 32'h0);
        check("R7 shrink", 32'(cur_sof), 2);
        rd(7'd40); check("R3 read after shrink", 32'(rd_illegal), 1);
        step(3'd2, 7'd0, 7'd11, 7'd0, 4'd0, 7'd43, 32'h0, 1'b0, 7'd32, 32'h0);
        rd(7'd40); check("R8 illegal target skipped", rd_data, 32'h6060_0005);

        reset_check();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule